// File: doc/BRIEF.md
# Display Attribute Latch with Inactivity Blanker

This block holds one CPU-written byte of display and system control. Three of its bits act directly: one selects the text width (80 or 132 columns), one suppresses processor interrupts while it is high, and one arms a screen saver. The remaining five bits go out unchanged to drive the serial lines of a nonvolatile setup memory. The CPU loads the byte with a single-cycle write strobe.

The screen saver is a small state machine with a tick counter. When it is armed and no byte has arrived from the host receive path or the keyboard for a set number of clock ticks, the blank output goes high. The default of 540,000,000 ticks gives about nine minutes at a 1 MHz tick. A byte from either source restarts the count and lifts the blanking. The timeout is a parameter, so a bench can use a short value.

The saver has three states. `SV_OFF` means disarmed, with the counter held at zero. `SV_COUNT` means armed and counting idle ticks. `SV_BLANK` means the timeout has expired. There are six transitions:
- `arm` (OFF to COUNT): the enable bit is seen high.
- `expire` (COUNT to BLANK): the counter sits at its limit and no activity arrives.
- `wake` (BLANK to COUNT): a host or keyboard strobe arrives.
- `restart` (COUNT to COUNT): activity clears the counter.
- `disarm_c` (COUNT to OFF) and `disarm_b` (BLANK to OFF): the enable bit is seen low.

Top module: `attr_blank_ctrl`

## Requirements
- R1: After reset, `blank`, `wide_mode`, `irq_kill` and `nvm_bits` are all 0. This means 80 columns, display visible and interrupts allowed.
- R2: A clock edge with `wr_en` high stores `wr_data`, and the outputs show the new value right after that edge. While `wr_en` is low, the stored byte does not change.
- R3: `wide_mode` follows stored bit 1: 0 selects 80 columns and 1 selects 132 columns.
- R4: `irq_kill` follows stored bit 2. It is high, meaning interrupts are suppressed, exactly while that bit is 1.
- R5: `nvm_bits[4:0]` equals stored bits [7:3], unchanged.
- R6: Stored bit 0 arms the saver. With no activity, `blank` is low for TIMEOUT_TICKS edges after the edge that wrote the bit from 0 to 1. It rises on edge TIMEOUT_TICKS+1 after that write and then stays high.
- R7: While the saver is armed, a clock edge with `host_rx_stb` or `kbd_stb` high drives `blank` low right after that edge. `blank` then stays low until it rises exactly TIMEOUT_TICKS edges later, provided no further activity arrives.
- R8: Right after the edge that writes bit 0 as 0, `blank` is low, and it stays low for as long as the bit stays 0. Arming the saver again restarts the full R6 interval.
- R9: A write that leaves bit 0 at 1 does not restart or disturb the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timeout tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | Byte to store |
| host_rx_stb | input | 1 | One pulse per byte received from the host |
| kbd_stb | input | 1 | One pulse per keyboard byte |
| blank | output | 1 | High blanks the screen |
| wide_mode | output | 1 | 0 selects 80 columns, 1 selects 132 columns |
| irq_kill | output | 1 | High suppresses interrupts |
| nvm_bits | output | 5 | Raw control and data lines for the setup memory |

## Verification
The attribute fields (R2 to R5) are due at the first falling edge after the write edge. The timeout is due TIMEOUT_TICKS+1 edges after an arming write, or TIMEOUT_TICKS edges after an activity strobe. Each driver task returns at the falling edge that follows its active edge, so it knows the cycle number of that edge. It queues each expected value under an absolute cycle number measured from there, including the cycle just before each timeout, where `blank` must still be low. A monitor samples just after every falling edge and compares only the items due in that cycle, so each check lands in the exact cycle its requirement names.

// File: rtl/attr_pkg.sv
package attr_pkg;

    typedef struct packed {
        logic [4:0] nvm;
        logic       irq_kill;
        logic       wide;
        logic       saver_en;
    } attr_t;

    typedef enum logic [1:0] {
        SV_OFF   = 2'd0,
        SV_COUNT = 2'd1,
        SV_BLANK = 2'd2
    } saver_state_t;

endpackage

// File: rtl/attr_latch.sv
module attr_latch
    import attr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output attr_t            q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= attr_t'(wr_data);
    end

    // R2: a write is stored, and the latch holds without one
    assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q == attr_t'($past(wr_data)));
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/saver_timer.sv
module saver_timer
    import attr_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 540_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic activity,
    output logic blank
);

    localparam int unsigned CW = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_TICKS - 1);

    saver_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SV_OFF: begin
                cnt_nx = '0;
                if (enable) state_nx = SV_COUNT;              // arm
            end
            SV_COUNT: begin
                if (!enable) begin
                    state_nx = SV_OFF;                        // disarm_c
                    cnt_nx   = '0;
                end else if (activity) begin
                    cnt_nx   = '0;                            // restart
                end else if (cnt == LIMIT) begin
                    state_nx = SV_BLANK;                      // expire
                    cnt_nx   = '0;
                end else begin
                    cnt_nx   = cnt + 1'b1;
                end
            end
            SV_BLANK: begin
                cnt_nx = '0;
                if (!enable)       state_nx = SV_OFF;         // disarm_b
                else if (activity) state_nx = SV_COUNT;       // wake
            end
            default: begin
                state_nx = SV_OFF;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SV_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs: blanking is dropped as soon as the enable bit goes low
    always_comb begin
        blank = (state == SV_BLANK) && enable;
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
    assert_blank_only_after_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == SV_BLANK) |-> $past(cnt) == LIMIT);
    assert_activity_unblanks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (activity && state != SV_OFF) |=> (!blank && cnt == '0));
    assert_blank_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> enable);
    assert_off_holds_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SV_OFF) |-> cnt == '0);

endmodule

// File: rtl/attr_blank_ctrl.sv
module attr_blank_ctrl
    import attr_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 540_000_000,
    parameter int          DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              host_rx_stb,
    input  logic              kbd_stb,
    output logic              blank,
    output logic              wide_mode,
    output logic              irq_kill,
    output logic [4:0]        nvm_bits
);

    attr_t attr_q;
    logic  activity;

    assign activity = host_rx_stb | kbd_stb;

    attr_latch #(.WIDTH(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (attr_q)
    );

    saver_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_saver (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (attr_q.saver_en),
        .activity (activity),
        .blank    (blank)
    );

    assign wide_mode = attr_q.wide;
    assign irq_kill  = attr_q.irq_kill;
    assign nvm_bits  = attr_q.nvm;

    // R4, R3: field outputs move only on a write edge
    assert_irq_kill_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq_kill));
    assert_wide_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wide_mode));

endmodule

// File: tb/attr_blank_ctrl_test.sv
module attr_blank_ctrl_test;

    localparam int T = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       host_rx_stb = 1'b0;
    logic       kbd_stb = 1'b0;
    logic       blank, wide_mode, irq_kill;
    logic [4:0] nvm_bits;

    int cyc = 0;
    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] mask;
        logic [7:0] val;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    attr_blank_ctrl #(.TIMEOUT_TICKS(T)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .host_rx_stb(host_rx_stb), .kbd_stb(kbd_stb),
        .blank(blank), .wide_mode(wide_mode), .irq_kill(irq_kill), .nvm_bits(nvm_bits)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // observed vector: [7:3] nvm, [2] irq_kill, [1] wide_mode, [0] blank
    wire [7:0] obs = {nvm_bits, irq_kill, wide_mode, blank};

    // monitor: compares items that fall due in the current cycle
    always begin
        @(negedge clk);
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                tests++;
                if ((obs & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
                    failed++;
                    $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                             sb[i].tag, cyc, obs & sb[i].mask,
                             sb[i].val & sb[i].mask, sb[i].mask);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(int at, logic [7:0] mask, logic [7:0] val, string tag);
        item_t it;
        it.at = at; it.mask = mask; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_blank(int at, logic b, string tag);
        expect_at(at, 8'h01, {7'd0, b}, tag);
    endtask

    // write one byte; returns at the falling edge after the write edge
    task automatic cpu_write(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_host();
        @(negedge clk);
        host_rx_stb = 1'b1;
        @(negedge clk);
        host_rx_stb = 1'b0;
    endtask

    task automatic pulse_kbd();
        @(negedge clk);
        kbd_stb = 1'b1;
        @(negedge clk);
        kbd_stb = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int e;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        expect_at(cyc, 8'hFF, 8'h00, "R1 reset state");
        idle(2);

        // R2..R5: fields, saver disarmed
        cpu_write(8'b1011_0110);
        e = cyc;
        expect_at(e, 8'hFE, 8'b1011_0110, "R2 write visible after edge");
        expect_at(e, 8'h02, 8'h02, "R3 bit1=1 selects 132 columns");
        expect_at(e, 8'h04, 8'h04, "R4 irq_kill high");
        expect_at(e, 8'hF8, 8'b1011_0000, "R5 nvm_bits raw");
        expect_at(e + 3, 8'hFE, 8'b1011_0110, "R2 hold without write");
        idle(4);
        cpu_write(8'b0100_1000);
        e = cyc;
        expect_at(e, 8'h02, 8'h00, "R3 bit1=0 selects 80 columns");
        expect_at(e, 8'h04, 8'h00, "R4 irq_kill low");
        expect_at(e, 8'hF8, 8'b0100_1000, "R5 nvm_bits second pattern");
        // R8: disarmed, activity ignored, no blank
        idle(2);
        pulse_host();
        expect_blank(cyc + 2 * T, 1'b0, "R8 disarmed never blanks");
        idle(2 * T + 2);

        // R6: arm, exact timeout
        cpu_write(8'h01);
        e = cyc;
        expect_blank(e + T, 1'b0, "R6 not yet blank");
        expect_blank(e + T + 1, 1'b1, "R6 blank at timeout");
        expect_blank(e + T + 5, 1'b1, "R6 blank stays high");
        idle(T + 6);

        // R7: keyboard wakes from blank
        pulse_kbd();
        e = cyc;
        expect_blank(e, 1'b0, "R7 kbd unblanks");
        expect_blank(e + T - 1, 1'b0, "R7 still counting");
        expect_blank(e + T, 1'b1, "R7 blank again after kbd");
        idle(T + 2);
        // R7: host strobe mid-count restarts
        pulse_host();
        idle(4);
        pulse_host();
        e = cyc;
        expect_blank(e + T - 1, 1'b0, "R7 host restart not yet blank");
        expect_blank(e + T, 1'b1, "R7 blank after host restart");
        idle(T + 2);

        // R8: disarm lifts blank immediately
        cpu_write(8'h00);
        e = cyc;
        expect_blank(e, 1'b0, "R8 disarm unblanks at once");
        idle(3);
        // R8/R9: arm, partial count, disarm, re-arm, then write keeping enable
        cpu_write(8'h01);
        idle(5);
        cpu_write(8'h00);
        idle(2);
        cpu_write(8'h01);
        e = cyc;
        idle(3);
        cpu_write(8'h05);
        expect_at(cyc, 8'h04, 8'h04, "R9 second write applied");
        expect_blank(e + T, 1'b0, "R8/R9 full interval after re-arm");
        expect_blank(e + T + 1, 1'b1, "R9 write did not restart count");
        idle(T + 2);

        while (sb.size() != 0) idle(1);
        idle(1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule